// File: doc/BRIEF.md
# Posted Write Acceptance Controller

This block is the target half of a bridge on the bus where a write starts. It recognises memory write and memory-write-and-invalidate commands. It accepts their data phases without wait states and pushes every accepted DWORD into a posted write queue. Each pushed entry carries the DWORD address, the byte enables and an end-of-transaction tag, so the side that forwards the writes can rebuild the transaction boundaries.

The block decides when a burst must stop. It issues a target disconnect when the queue takes its last free entry. For memory-write-and-invalidate it also disconnects when the next DWORD would start a new cache line. The line size in DWORDs is read from a register input and latched at the address phase. If the queue is already full when a write is addressed, the block answers with a retry and accepts no data.

Top module: `pw_accept`

## Requirements
- R1: While reset is asserted and until the first address phase after it, trdy_n and stop_n are high and q_push is low.
- R2: Only command code 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) on cbe_n in the address phase are claimed. Any other code produces no trdy_n, no stop_n and no push for the whole transaction.
- R3: In a claimed write, trdy_n is low in every data phase, from the first one on, while the queue is not full. Every cycle with irdy_n and trdy_n both low pushes exactly one entry. The entry holds q_data = ad, q_be_n = cbe_n and q_addr = the address-phase ad[31:2] plus the number of DWORDs already accepted.
- R4: A DWORD accepted while frame_n is high (the initiator's last data phase) is pushed with q_eot high. A DWORD accepted with frame_n low and no disconnect is pushed with q_eot low.
- R5: When q_afull is high (one entry free), stop_n is driven low together with trdy_n, and the DWORD accepted in that phase is pushed with q_eot high.
- R6: For a memory write and invalidate with a line size of 4, 8, 16 or 32 DWORDs, stop_n is low with trdy_n in the data phase whose next DWORD address modulo the line size is zero. That DWORD is pushed with q_eot high.
- R7: A line size other than 4, 8, 16 or 32 causes no boundary disconnect, and neither does any line size on a plain memory write. Such bursts run until the initiator ends them or the queue fills.
- R8: A write addressed while q_full is high is retried. stop_n goes low with trdy_n high from the first data phase, and nothing is pushed.
- R9: Once stop_n has been driven low, it stays low until the data phase in which frame_n is high. A DWORD accepted with stop_n low ends the acceptance: later phases of that transaction show trdy_n high and push nothing, and stop_n returns high after frame_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Initiator transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address in the address phase, write data in data phases |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| cls | input | 8 | Cache line size in DWORDs |
| q_full | input | 1 | Posted write queue has no free entry |
| q_afull | input | 1 | Posted write queue has exactly one free entry |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| q_push | output | 1 | Write one entry into the queue |
| q_data | output | 32 | Entry data |
| q_be_n | output | 4 | Entry byte enables, active low |
| q_addr | output | 30 | Entry DWORD address |
| q_eot | output | 1 | Entry is the last of its transaction |

## Verification
Two causes of a disconnect can coincide in one data phase. The queue reaching its last free entry and a memory write and invalidate reaching a cache line boundary may hit the same DWORD. A stop held over from a stalled phase can also meet the initiator's own final phase. The sweep sets the starting queue fill just below full and steps the start address across every offset inside small lines. It inserts initiator wait states on a varying pattern, so both causes and the initiator's end land on the same DWORD in many combinations. Each of these phases must show exactly one push with q_eot high and a single stop that stays low until frame_n rises.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_STOP,
    ST_SKIP
  } pwa_state_e;

  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

endpackage

// File: rtl/pwa_line_cfg.sv
module pwa_line_cfg #(
  parameter int CLS_W    = 8,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CLS_W-1:0]    cls,
  output logic                line_ok,
  output logic [MAX_LOG2-1:0] line_mask
);

  logic [MAX_LOG2:0]   hit;
  logic [CLS_W-1:0]    cls_m1;
  logic                ok_d;
  logic [MAX_LOG2-1:0] mask_d;

  // one comparator per permitted line size
  for (genvar g = 0; g <= MAX_LOG2; g++) begin : g_size
    if (g >= MIN_LOG2) begin : g_on
      assign hit[g] = (cls == CLS_W'(1 << g));
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  assign cls_m1 = cls - CLS_W'(1);

  always_comb begin
    ok_d   = line_ok;
    mask_d = line_mask;
    if (load) begin
      ok_d   = |hit;
      mask_d = (|hit) ? cls_m1[MAX_LOG2-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ok   <= 1'b0;
      line_mask <= '0;
    end else begin
      line_ok   <= ok_d;
      line_mask <= mask_d;
    end
  end

  // R6: an accepted size is always a contiguous low mask
  p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> ((line_mask & (line_mask + MAX_LOG2'(1))) == '0));

endmodule

// File: rtl/pwa_addr_ctr.sv
module pwa_addr_ctr #(
  parameter int ADDR_W = 30,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic [MASK_W-1:0] mask,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              at_boundary
);

  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] addr_d;

  assign nxt_addr    = cur_addr + ADDR_W'(1);
  assign at_boundary = ((nxt_addr[MASK_W-1:0] & mask) == '0);

  always_comb begin
    addr_d = cur_addr;
    if (load)     addr_d = load_addr;
    else if (adv) addr_d = nxt_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_addr <= '0;
    else        cur_addr <= addr_d;
  end

  // R3: each accepted DWORD moves the address on by exactly one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

endmodule

// File: rtl/pwa_tgt_fsm.sv
module pwa_tgt_fsm
  import pwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic [3:0] cmd,
  input  logic       q_full,
  input  logic       q_afull,
  input  logic       line_ok,
  input  logic       at_boundary,
  output logic       trdy_n,
  output logic       stop_n,
  output logic       xfer,
  output logic       eot,
  output logic       addr_phase
);

  pwa_state_e state_q, state_d;
  logic       mwi_q, mwi_d;
  logic       pend_q, pend_d;
  logic       is_wr;
  logic       stop_cond;

  assign is_wr     = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV);
  assign stop_cond = q_afull || (mwi_q && line_ok && at_boundary) || pend_q;

  always_comb begin
    state_d    = state_q;
    mwi_d      = mwi_q;
    pend_d     = pend_q;
    trdy_n     = 1'b1;
    stop_n     = 1'b1;
    xfer       = 1'b0;
    eot        = 1'b0;
    addr_phase = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          addr_phase = 1'b1;
          pend_d     = 1'b0;
          if (is_wr) begin
            mwi_d   = (cmd == CMD_MEM_WR_INV);
            state_d = q_full ? ST_STOP : ST_DATA;
          end else begin
            state_d = ST_SKIP;
          end
        end
      end
      ST_DATA: begin
        if (q_full) begin
          stop_n  = 1'b0;
          state_d = frame_n ? ST_IDLE : ST_STOP;
        end else begin
          trdy_n = 1'b0;
          stop_n = !stop_cond;
          xfer   = !irdy_n;
          eot    = !irdy_n && (frame_n || stop_cond);
          if (!irdy_n) begin
            if (frame_n)        state_d = ST_IDLE;
            else if (stop_cond) state_d = ST_STOP;
          end else if (stop_cond) begin
            pend_d = 1'b1;
          end
        end
      end
      ST_STOP: begin
        stop_n = 1'b0;
        if (frame_n) state_d = ST_IDLE;
      end
      default: begin
        if (frame_n) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mwi_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mwi_q   <= mwi_d;
      pend_q  <= pend_d;
    end
  end

  // R9: a stop shown while the initiator still frames persists
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

  // R8: a write addressed against a full queue is retried
  p_retry_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && is_wr && q_full) |=> (trdy_n && !stop_n));

  // R6: a line-crossing invalidate write is disconnected on that DWORD
  p_boundary_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mwi_q && line_ok && at_boundary) |-> !stop_n);

endmodule

// File: rtl/pw_accept.sv
module pw_accept #(
  parameter int DATA_W   = 32,
  parameter int CLS_W    = 8,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [31:0]       ad,
  input  logic [3:0]        cbe_n,
  input  logic [7:0]        cls,
  input  logic              q_full,
  input  logic              q_afull,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              q_push,
  output logic [31:0]       q_data,
  output logic [3:0]        q_be_n,
  output logic [29:0]       q_addr,
  output logic              q_eot
);

  localparam int ADDR_W = DATA_W - 2;

  logic       rst_meta_n, rst_sync_n;
  logic       line_ok, at_boundary, xfer, eot, addr_phase;
  logic [MAX_LOG2-1:0] line_mask;
  logic [ADDR_W-1:0]   cur_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pwa_line_cfg #(.CLS_W(CLS_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_line (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (addr_phase),
    .cls       (cls),
    .line_ok   (line_ok),
    .line_mask (line_mask)
  );

  pwa_addr_ctr #(.ADDR_W(ADDR_W), .MASK_W(MAX_LOG2)) u_addr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load        (addr_phase),
    .load_addr   (ad[DATA_W-1:2]),
    .adv         (xfer),
    .mask        (line_mask),
    .cur_addr    (cur_addr),
    .at_boundary (at_boundary)
  );

  pwa_tgt_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .cmd         (cbe_n),
    .q_full      (q_full),
    .q_afull     (q_afull),
    .line_ok     (line_ok),
    .at_boundary (at_boundary),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .xfer        (xfer),
    .eot         (eot),
    .addr_phase  (addr_phase)
  );

  assign q_push = xfer;
  assign q_data = ad;
  assign q_be_n = cbe_n;
  assign q_addr = cur_addr;
  assign q_eot  = eot;

  // R4: a transaction's tagged last entry is followed by a gap in pushes
  p_eot_ends_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q_push && q_eot) |=> !q_push);

  // R5: taking the last free entry disconnects and closes the transaction
  p_last_slot_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q_push && q_afull) |-> (!stop_n && q_eot));

  // R3: a push only happens on a completed data phase
  p_push_handshake_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    q_push |-> (!irdy_n && !trdy_n && !q_full));

endmodule

// File: tb/pw_accept_tb.sv
module pw_accept_tb;

  localparam int CLK_P = 10;
  localparam int DEPTH = 40;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n, frame_n, irdy_n, q_full, q_afull;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic [7:0]  cls;
  logic        trdy_n, stop_n, q_push, q_eot;
  logic [31:0] q_data;
  logic [3:0]  q_be_n;
  logic [29:0] q_addr;

  int n_vec = 0;
  int n_bad = 0;
  int cnt   = 0;
  int cyc   = 0;

  always #(CLK_P/2) clk = ~clk;

  pw_accept u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .cls(cls), .q_full(q_full), .q_afull(q_afull),
    .trdy_n(trdy_n), .stop_n(stop_n), .q_push(q_push), .q_data(q_data),
    .q_be_n(q_be_n), .q_addr(q_addr), .q_eot(q_eot)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        n_bad++;
        $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WDOG);
        report();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, leave outputs to settle
  task automatic drive(input logic f, input logic i, input logic [31:0] a,
                       input logic [3:0] c);
    @(negedge clk);
    frame_n = f; irdy_n = i; ad = a; cbe_n = c;
    q_full  = (cnt == DEPTH);
    q_afull = (cnt == DEPTH - 1);
    #(CLK_P/4);
  endtask

  function automatic bit line_valid(input int s);
    return (s == 4) || (s == 8) || (s == 16) || (s == 32);
  endfunction

  task automatic run_txn(input logic [3:0] cmd, input logic [29:0] dwa,
                         input int len, input int lsz, input int start_cnt,
                         input int stall_pat);
    bit    is_wr, mwi, tgt_stop, seen_stop, pend, done, stall, stop_e, push_e;
    int    k, c;
    logic  f, i;
    logic [31:0] dat;
    logic [3:0]  be;
    string tag;
    is_wr = (cmd == 4'b0111) || (cmd == 4'b1111);
    mwi   = (cmd == 4'b1111);
    cnt   = start_cnt;
    cls   = 8'(lsz);
    drive(1'b0, 1'b1, {dwa, 2'b00}, cmd);
    chk({trdy_n, stop_n, q_push} == 3'b110, "R1 addr phase", {trdy_n, stop_n, q_push}, 3'b110);
    tgt_stop = is_wr && (start_cnt == DEPTH);
    seen_stop = 0; pend = 0; done = 0; k = 0; c = 0;
    while (!done) begin
      stall = !seen_stop && (((stall_pat >> (c % 16)) & 1) == 1);
      if (stall) begin f = 1'b0; i = 1'b1; end
      else begin f = (k == len - 1) || seen_stop; i = 1'b0; end
      dat = 32'h5A5A_0000 + 32'(k * 7) + 32'(dwa);
      be  = 4'(k) ^ 4'h5;
      drive(f, i, dat, be);
      if (!is_wr) begin
        chk({trdy_n, stop_n, q_push} == 3'b110, "R2", {trdy_n, stop_n, q_push}, 3'b110);
        if (!i) k++;
        done = f;
      end else if (tgt_stop) begin
        tag = (start_cnt == DEPTH && k == 0) ? "R8" : "R9";
        chk({trdy_n, stop_n, q_push} == 3'b100, tag, {trdy_n, stop_n, q_push}, 3'b100);
        seen_stop = 1;
        done = f;
      end else begin
        stop_e = (cnt == DEPTH - 1) || pend ||
                 (mwi && line_valid(lsz) && ((int'(dwa) + k + 1) % lsz == 0));
        push_e = !i;
        if (cnt == DEPTH - 1)                tag = "R5";
        else if (stop_e && mwi)              tag = "R6";
        else if (mwi && line_valid(lsz))     tag = "R3";
        else                                 tag = "R7";
        chk({trdy_n, stop_n, q_push} == {1'b0, !stop_e, push_e}, tag,
            {trdy_n, stop_n, q_push}, {1'b0, !stop_e, push_e});
        if (push_e && q_push) begin
          chk({q_data, q_be_n, q_addr} == {dat, be, dwa + 30'(k)}, "R3 entry",
              {q_data, q_be_n, q_addr}, {dat, be, dwa + 30'(k)});
          chk(q_eot == (f || stop_e), "R4 eot", q_eot, f || stop_e);
        end
        if (stop_e) seen_stop = 1;
        if (push_e) begin
          k++; cnt++;
          if (f) done = 1;
          else if (stop_e) tgt_stop = 1;
        end else if (stop_e) pend = 1;
      end
      c++;
    end
    drive(1'b1, 1'b1, 32'h0, 4'hF);
    chk({trdy_n, stop_n, q_push} == 3'b110, "R9 released", {trdy_n, stop_n, q_push}, 3'b110);
  endtask

  initial begin
    int lsz_set[8] = '{0, 2, 4, 8, 16, 32, 64, 12};
    int len_set[4] = '{1, 3, 9, 33};
    int cnt_set[4] = '{0, DEPTH - 3, DEPTH - 1, DEPTH};
    logic [3:0] cmd_set[4] = '{4'b0111, 4'b1111, 4'b0110, 4'b0011};
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
    cls = 8'd8; q_full = 1'b0; q_afull = 1'b0;
    repeat (3) drive(1'b1, 1'b1, 32'h0, 4'hF);
    chk({trdy_n, stop_n, q_push} == 3'b110, "R1 in reset", {trdy_n, stop_n, q_push}, 3'b110);
    drive(1'b0, 1'b0, 32'h0, 4'b0111);
    chk({trdy_n, stop_n, q_push} == 3'b110, "R1 frame in reset", {trdy_n, stop_n, q_push}, 3'b110);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) drive(1'b1, 1'b1, 32'h0, 4'hF);
    chk({trdy_n, stop_n, q_push} == 3'b110, "R1 after reset", {trdy_n, stop_n, q_push}, 3'b110);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 8; o++)
          for (int l = 0; l < 4; l++)
            for (int q = 0; q < 4; q++)
              run_txn(cmd_set[m], 30'h0000_1000 + 30'(o), len_set[l], lsz_set[s],
                      cnt_set[q], (o * 37 + l * 11 + q) & 16'h5A5A);
    report();
  end

endmodule